// File: doc/BRIEF.md
# 4B3T Ternary Line Codec

This block turns a stream of 4-bit nibbles into three-symbol ternary codewords and turns such codewords back into nibbles. Each symbol takes one of the levels -1, 0 and +1. Sixteen nibble values map into 27 possible triplets. The spare triplets let the encoder keep the line free of DC content.

Six nibbles have a single codeword whose symbols sum to zero. Each of the other ten nibbles has two codewords: one with a positive weight and one with a negative weight. The encoder keeps a running disparity with a value from 1 to 4. For each nibble it picks the alternative that keeps this value in range, then adds the weight of the emitted codeword to it. The triplet of three zero symbols is never used for data. This bounds the length of zero runs on the line, so a comma pattern built by framing logic stays unique.

A load input lets the framing logic set the disparity after it sends a start delimiter. The decoder accepts either alternative in any state and flags every triplet that is not a data codeword.

Top module: `t43_codec`

## Requirements
- R1: Six nibbles have one zero-weight codeword that the encoder emits in every disparity state: 0001→(0,-,+), 0010→(+,-,0), 0100→(-,+,0), 0111→(-,0,+), 1011→(+,0,-), 1110→(0,+,-).
- R2: Each other nibble has a positive-weight codeword and a negative-weight codeword. The encoder emits the positive one when the disparity plus its weight is at most 4, and the negative one otherwise. The pairs are: 0000 (+,0,+)/(0,-,0); 0011 (0,0,+)/(-,-,0); 0101 (0,+,+)/(-,0,0); 0110 (-,+,+)/(-,-,+); 1000 (+,0,0)/(0,-,-); 1001 (+,-,+)/(-,-,-); 1010 (+,+,-)/(+,-,-); 1100 (+,+,+)/(-,+,-); 1101 (0,+,0)/(-,0,-); 1111 (+,+,0)/(0,0,-).
- R3: After reset the disparity is 1 and no triplet is presented.
- R4: Each emitted triplet adds its weight to the disparity. The disparity never leaves the range 1 to 4.
- R5: When `rd_load` is high, the disparity becomes `rd_load_val`+1. A nibble accepted in the same cycle is encoded against the loaded value.
- R6: `tx_ready` is low during reset and otherwise equals (no triplet held) OR `tx_sym_ready`. An accepted nibble appears on `tx_sym` in the next cycle. A triplet that is not taken stays unchanged.
- R7: Each symbol is 2 bits: 01 = +1, 00 = 0, 11 = -1. The first symbol is in bits [5:4] and the last is in bits [1:0]. The encoder never emits 10 and never emits the all-zero triplet.
- R8: The decoder maps both codewords of every nibble back to that nibble, whatever the disparity, one cycle after `rx_valid`.
- R9: `rx_viol` is set, and `rx_nibble` is 0, for the all-zero triplet, for any unused triplet and for any triplet that contains the symbol value 10.
- R10: `rx_nib_valid` follows `rx_valid` with one cycle of delay. `rx_viol` is low whenever `rx_nib_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Nibble offered |
| tx_ready | output | 1 | Nibble taken this cycle when high with tx_valid |
| tx_nibble | input | 4 | Nibble to encode |
| tx_sym_ready | input | 1 | Downstream takes the held triplet |
| tx_sym_valid | output | 1 | Triplet on tx_sym is valid |
| tx_sym | output | 6 | Encoded triplet, first symbol in [5:4] |
| rd_load | input | 1 | Force the disparity |
| rd_load_val | input | 2 | Disparity to load, minus one |
| rx_valid | input | 1 | Received triplet valid |
| rx_sym | input | 6 | Received triplet, first symbol in [5:4] |
| rx_nib_valid | output | 1 | Decoded result valid |
| rx_nibble | output | 4 | Decoded nibble |
| rx_viol | output | 1 | Triplet is not a data codeword |

## Verification
On every cycle the assertions check several properties. The disparity must move by exactly the weight of the triplet just emitted and must stay in range. A stalled triplet must hold steady. No emitted triplet may be all zeros or contain the illegal symbol value. The decoder's valid flag must track its input with one cycle of delay, and a flagged violation must carry a zero nibble. Only the bench's scenarios can show that the right alternative is chosen in each of the four states, including just after reset and after a load. They also show that every codeword decodes to its own nibble and that all 64 six-bit patterns are sorted correctly into data and violations.

// File: rtl/t43_pkg.sv
package t43_pkg;
  localparam int NIB_W  = 4;
  localparam int SYM_W  = 2;
  localparam int TRI_N  = 3;
  localparam int TRI_W  = SYM_W * TRI_N;
  localparam int LVL_W  = 2;
  localparam int N_NIB  = 1 << NIB_W;

  localparam logic [SYM_W-1:0] SP = 2'b01;
  localparam logic [SYM_W-1:0] SZ = 2'b00;
  localparam logic [SYM_W-1:0] SN = 2'b11;

  typedef logic [TRI_W-1:0] tri_t;

  // Positive-weight (or sole zero-weight) codeword of a nibble
  function automatic tri_t code_pos(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: return {SP, SZ, SP};
      4'h1: return {SZ, SN, SP};
      4'h2: return {SP, SN, SZ};
      4'h3: return {SZ, SZ, SP};
      4'h4: return {SN, SP, SZ};
      4'h5: return {SZ, SP, SP};
      4'h6: return {SN, SP, SP};
      4'h7: return {SN, SZ, SP};
      4'h8: return {SP, SZ, SZ};
      4'h9: return {SP, SN, SP};
      4'hA: return {SP, SP, SN};
      4'hB: return {SP, SZ, SN};
      4'hC: return {SP, SP, SP};
      4'hD: return {SZ, SP, SZ};
      4'hE: return {SZ, SP, SN};
      default: return {SP, SP, SZ};
    endcase
  endfunction

  // Negative-weight (or sole zero-weight) codeword of a nibble
  function automatic tri_t code_neg(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: return {SZ, SN, SZ};
      4'h1: return {SZ, SN, SP};
      4'h2: return {SP, SN, SZ};
      4'h3: return {SN, SN, SZ};
      4'h4: return {SN, SP, SZ};
      4'h5: return {SN, SZ, SZ};
      4'h6: return {SN, SN, SP};
      4'h7: return {SN, SZ, SP};
      4'h8: return {SZ, SN, SN};
      4'h9: return {SN, SN, SN};
      4'hA: return {SP, SN, SN};
      4'hB: return {SP, SZ, SN};
      4'hC: return {SN, SP, SN};
      4'hD: return {SN, SZ, SN};
      4'hE: return {SZ, SP, SN};
      default: return {SZ, SZ, SN};
    endcase
  endfunction

  // Sum of the symbol levels of a triplet
  function automatic logic signed [3:0] tri_weight(input tri_t t);
    logic signed [3:0] acc;
    acc = 4'sd0;
    for (int k = 0; k < TRI_N; k++) begin
      if (t[k*SYM_W +: SYM_W] == SP) acc = acc + 4'sd1;
      else if (t[k*SYM_W +: SYM_W] == SN) acc = acc - 4'sd1;
    end
    return acc;
  endfunction
endpackage

// File: rtl/t43_sel.sv
module t43_sel
  import t43_pkg::*;
(
  input  logic [NIB_W-1:0]  nib_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output tri_t              code_o,
  output logic signed [3:0] lvl_nx_o
);
  tri_t              cp, cn;
  logic signed [3:0] wp, wn, lvl_s;
  logic              use_pos;

  always_comb begin
    cp      = code_pos(nib_i);
    cn      = code_neg(nib_i);
    wp      = tri_weight(cp);
    wn      = tri_weight(cn);
    lvl_s   = $signed({2'b00, lvl_i});
    // levels 0..3 stand for disparity 1..4
    use_pos = (lvl_s + wp) <= 4'sd3;
    code_o  = use_pos ? cp : cn;
    lvl_nx_o = lvl_s + (use_pos ? wp : wn);
  end
endmodule

// File: rtl/t43_enc.sv
module t43_enc
  import t43_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NIB_W-1:0] in_nib,
  input  logic             out_ready,
  output logic             out_valid,
  output tri_t             out_sym,
  input  logic             ld,
  input  logic [LVL_W-1:0] ld_val
);
  logic              hold_v;
  tri_t              hold_sym;
  logic [LVL_W-1:0]  lvl_q, lvl_eff;
  tri_t              code;
  logic signed [3:0] lvl_nx;
  logic              acc;

  assign in_ready  = !rst && (!hold_v || out_ready);
  assign acc       = in_valid && in_ready;
  assign lvl_eff   = ld ? ld_val : lvl_q;
  assign out_valid = hold_v;
  assign out_sym   = hold_sym;

  t43_sel u_sel (
    .nib_i    (in_nib),
    .lvl_i    (lvl_eff),
    .code_o   (code),
    .lvl_nx_o (lvl_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v   <= 1'b0;
      hold_sym <= '0;
      lvl_q    <= '0;
    end else if (acc) begin
      hold_v   <= 1'b1;
      hold_sym <= code;
      lvl_q    <= lvl_nx[LVL_W-1:0];
    end else begin
      lvl_q <= lvl_eff;
      if (out_ready) hold_v <= 1'b0;
    end
  end

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    acc |-> (lvl_nx >= 4'sd0 && lvl_nx <= 4'sd3)) else $error("level range"); // R4
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    acc |=> ($signed({2'b00, lvl_q}) == $signed({2'b00, $past(lvl_eff)}) + tri_weight(out_sym)))
    else $error("level step"); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym))) else $error("hold"); // R6
  AST_NO_ZERO_TRI: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sym != '0)) else $error("zero triplet"); // R7
  AST_NO_BAD_SYM: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sym[5:4] != 2'b10 && out_sym[3:2] != 2'b10 && out_sym[1:0] != 2'b10))
    else $error("bad symbol"); // R7
endmodule

// File: rtl/t43_dec.sv
module t43_dec
  import t43_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  tri_t             in_sym,
  output logic             out_valid,
  output logic [NIB_W-1:0] out_nib,
  output logic             out_viol
);
  logic [N_NIB-1:0] hit;
  logic [TRI_N-1:0] bad_sym;
  logic [NIB_W-1:0] nib_c;
  logic             viol_c;

  for (genvar i = 0; i < N_NIB; i++) begin : g_match
    assign hit[i] = (in_sym == code_pos(NIB_W'(i))) || (in_sym == code_neg(NIB_W'(i)));
  end

  for (genvar k = 0; k < TRI_N; k++) begin : g_sym
    assign bad_sym[k] = (in_sym[k*SYM_W +: SYM_W] == 2'b10);
  end

  always_comb begin
    nib_c = '0;
    for (int i = 0; i < N_NIB; i++)
      if (hit[i]) nib_c = nib_c | NIB_W'(i);
    viol_c = (hit == '0) || (|bad_sym);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_nib   <= '0;
      out_viol  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_viol  <= in_valid && viol_c;
      if (in_valid) out_nib <= viol_c ? '0 : nib_c;
    end
  end

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("latency"); // R10
  AST_DEC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_viol)) else $error("idle"); // R10
  AST_ZERO_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sym == '0) |=> out_viol) else $error("zero not flagged"); // R9
  AST_VIOL_NIB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_viol) |-> (out_nib == '0)) else $error("viol nibble"); // R9
endmodule

// File: rtl/t43_codec.sv
module t43_codec
  import t43_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [3:0] tx_nibble,
  input  logic       tx_sym_ready,
  output logic       tx_sym_valid,
  output logic [5:0] tx_sym,
  input  logic       rd_load,
  input  logic [1:0] rd_load_val,
  input  logic       rx_valid,
  input  logic [5:0] rx_sym,
  output logic       rx_nib_valid,
  output logic [3:0] rx_nibble,
  output logic       rx_viol
);
  t43_enc u_enc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (tx_valid),
    .in_ready  (tx_ready),
    .in_nib    (tx_nibble),
    .out_ready (tx_sym_ready),
    .out_valid (tx_sym_valid),
    .out_sym   (tx_sym),
    .ld        (rd_load),
    .ld_val    (rd_load_val)
  );

  t43_dec u_dec (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rx_valid),
    .in_sym    (rx_sym),
    .out_valid (rx_nib_valid),
    .out_nib   (rx_nibble),
    .out_viol  (rx_viol)
  );
endmodule

// File: tb/t43_codec_test.sv
module t43_codec_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_valid = 1'b0, tx_sym_ready = 1'b1, rd_load = 1'b0, rx_valid = 1'b0;
  logic [3:0] tx_nibble = '0;
  logic [1:0] rd_load_val = '0;
  logic [5:0] rx_sym = '0;
  logic       tx_ready, tx_sym_valid, rx_nib_valid, rx_viol;
  logic [5:0] tx_sym;
  logic [3:0] rx_nibble;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string tag_tx = "R2", tag_rx = "R8";

  // reference model state
  bit         m_v = 0;
  logic [5:0] m_sym = '0;
  int         m_st = 1;
  bit         m_rv = 0, m_rviol = 0;
  logic [3:0] m_rnib = '0;

  string pos_tab[16] = '{"+0+","0-+","+-0","00+","-+0","0++","-++","-0+",
                         "+00","+-+","++-","+0-","+++","0+0","0+-","++0"};
  string neg_tab[16] = '{"0-0","0-+","+-0","--0","-+0","-00","--+","-0+",
                         "0--","---","+--","+0-","-+-","-0-","0+-","00-"};

  always #4 clk = ~clk;

  t43_codec uut (.*);

  function automatic logic [5:0] to_bits(string s);
    logic [5:0] r = '0;
    for (int k = 0; k < 3; k++)
      r[(2-k)*2 +: 2] = (s[k] == "+") ? 2'b01 : (s[k] == "-") ? 2'b11 : 2'b00;
    return r;
  endfunction

  function automatic int wt(string s);
    int w = 0;
    for (int k = 0; k < 3; k++) begin
      if (s[k] == "+") w++;
      else if (s[k] == "-") w--;
    end
    return w;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive after a falling edge, check at the next falling edge
  task automatic step(bit v, logic [3:0] n, bit rdy, bit ld, logic [1:0] lv,
                      bit rv, logic [5:0] rs);
    bit    er;
    int    eff;
    string c;
    tx_valid = v; tx_nibble = n; tx_sym_ready = rdy; rd_load = ld; rd_load_val = lv;
    rx_valid = rv; rx_sym = rs;
    er  = !m_v || rdy;
    eff = ld ? int'(lv) + 1 : m_st;
    if (v && er) begin
      c     = (eff + wt(pos_tab[n]) <= 4) ? pos_tab[n] : neg_tab[n];
      m_st  = eff + wt(c);
      m_sym = to_bits(c);
      m_v   = 1;
    end else begin
      m_st = eff;
      if (rdy) m_v = 0;
    end
    m_rv = rv;
    if (rv) begin
      m_rviol = 1; m_rnib = '0;
      for (int i = 0; i < 16; i++)
        if (rs == to_bits(pos_tab[i]) || rs == to_bits(neg_tab[i])) begin
          m_rviol = 0; m_rnib = 4'(i);
        end
    end else m_rviol = 0;
    #1;
    chk("R6", "tx_ready", int'(tx_ready), int'(er));
    @(negedge clk);
    chk("R6", "tx_sym_valid", int'(tx_sym_valid), int'(m_v));
    if (m_v) begin
      chk(tag_tx, "tx_sym", int'(tx_sym), int'(m_sym));
      chk("R7", "nonzero triplet", int'(tx_sym != 6'd0), 1);
    end
    chk("R10", "rx_nib_valid", int'(rx_nib_valid), int'(m_rv));
    chk(m_rv ? tag_rx : "R10", "rx_viol", int'(rx_viol), int'(m_rviol));
    if (m_rv) chk(tag_rx, "rx_nibble", int'(rx_nibble), int'(m_rnib));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R3: reset state
    chk("R3", "tx_ready in reset", int'(tx_ready), 0);
    chk("R3", "tx_sym_valid in reset", int'(tx_sym_valid), 0);
    chk("R10", "rx_nib_valid in reset", int'(rx_nib_valid), 0);
    rst = 1'b0;
    #1;
    chk("R3", "tx_ready after reset", int'(tx_ready), 1);
    @(negedge clk);
    // R3: disparity 1 after reset, so 1100 takes +++
    tag_tx = "R3";
    step(1, 4'hC, 1, 0, 0, 0, 0);
    chk("R3", "first code", int'(tx_sym), int'(6'b010101));
    step(0, 0, 1, 0, 0, 0, 0);

    // R1: zero-weight nibbles in each disparity state
    tag_tx = "R1";
    for (int s = 0; s < 4; s++) begin
      step(1, 4'h1, 1, 1, 2'(s), 0, 0);
      step(1, 4'h2, 1, 0, 0, 0, 0);
      step(1, 4'h4, 1, 0, 0, 0, 0);
      step(1, 4'h7, 1, 0, 0, 0, 0);
      step(1, 4'hB, 1, 0, 0, 0, 0);
      step(1, 4'hE, 1, 0, 0, 0, 0);
    end

    // R2 and R4: every nibble from every disparity state, then long streams
    tag_tx = "R2";
    for (int s = 0; s < 4; s++)
      for (int n = 0; n < 16; n++)
        step(1, 4'(n), 1, 1, 2'(s), 0, 0);
    tag_tx = "R4";
    for (int r = 0; r < 8; r++)
      for (int n = 0; n < 16; n++)
        step(1, 4'(n), 1, 0, 0, 0, 0);
    for (int r = 0; r < 40; r++) step(1, 4'hC, 1, 0, 0, 0, 0);
    for (int r = 0; r < 40; r++) step(1, 4'h9, 1, 0, 0, 0, 0);

    // R5: load with and without a nibble in the same cycle
    tag_tx = "R5";
    for (int s = 0; s < 4; s++) begin
      step(1, 4'h9, 1, 1, 2'(s), 0, 0);
      step(0, 0, 1, 1, 2'(3 - s), 0, 0);
      step(1, 4'h0, 1, 0, 0, 0, 0);
    end

    // R6: backpressure with random ready
    tag_tx = "R6";
    for (int r = 0; r < 600; r++)
      step(bit'($urandom % 4 != 0), 4'($urandom), bit'($urandom % 3 != 0), 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);

    // R8: both codewords of every nibble decode
    tag_rx = "R8";
    for (int n = 0; n < 16; n++) begin
      step(0, 0, 1, 0, 0, 1, to_bits(pos_tab[n]));
      step(0, 0, 1, 0, 0, 1, to_bits(neg_tab[n]));
    end

    // R9: every 6-bit pattern
    tag_rx = "R9";
    for (int p = 0; p < 64; p++) step(0, 0, 1, 0, 0, 1, 6'(p));
    step(0, 0, 1, 0, 0, 1, 6'b000000);
    step(0, 0, 1, 0, 0, 1, 6'b100101);

    // R10: gaps on the receive side
    tag_rx = "R10";
    for (int r = 0; r < 200; r++)
      step(0, 0, 1, 0, 0, bit'($urandom % 2), 6'($urandom));

    // mixed traffic with loads
    tag_tx = "R4"; tag_rx = "R8";
    for (int r = 0; r < 1500; r++)
      step(bit'($urandom % 4 != 0), 4'($urandom), bit'($urandom % 4 != 0),
           bit'($urandom % 50 == 0), 2'($urandom), bit'($urandom % 2), 6'($urandom));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule